// File: doc/BRIEF.md
# Slave-Mode Trigger Counter

This block is a 16-bit up/down counter run by a slave-mode controller. A 4-bit mode input selects how the counter is clocked, started, stopped or reinitialised. It can count on the internal clock, count quadrature edges from two channel inputs, be gated by a trigger line, start on a trigger edge, take the trigger as its clock, or be reset by the trigger. Reset can be combined with a start.

The trigger input and the two channel inputs are asynchronous to the block's clock. Each one passes through two synchronising flops and then an edge detector. The counter wraps against an auto-reload value. On a wrap or a trigger reinitialisation, an update pulse one cycle long appears on the cycle the new count appears. Configuration arrives on plain input ports: mode, enable level, direction and reload value.

Top module: `slave_timer_ctrl`

## Requirements
- R1: After reset the count is 0, the direction output is 0 (up) and the update pulse is low.
- R2: In mode 0000, and in the unused codes 1001 to 1111, the running counter steps once per clock. It steps down when `dir_i` is 1 and up when it is 0.
- R3: Stepping up from a count at or above `arr_i` gives 0. Stepping down from 0 gives `arr_i`. Each wrap raises `update_o` for exactly one cycle, together with the new count.
- R4: A run flag copies `en_i` on each change of `en_i`, and a start trigger sets it. While the run flag is clear, the count changes only through reinitialisation.
- R5: Mode 0001 steps only on edges of channel 1. The step is down when the new level of channel 1 equals the level of channel 2, and up otherwise.
- R6: Mode 0010 steps only on edges of channel 2. The step is down when the new level of channel 2 differs from the level of channel 1, and up otherwise.
- R7: Mode 0011 steps on edges of either channel, each using the rule of R5 or R6. A cycle in which both channels change at once gives no step.
- R8: In mode 0100, a rising trigger edge reinitialises the count and pulses `update_o`, whether or not the run flag is set. Reinitialisation loads 0 when `dir_i` is 0 and `arr_i` when `dir_i` is 1.
- R9: In mode 0101, the running counter steps only while the synchronised trigger is high. It holds its value, without clearing, while the trigger is low.
- R10: In mode 0110, a rising trigger edge sets the run flag without changing the count. Counting then continues after the trigger falls.
- R11: In mode 0111, the running counter steps once per rising trigger edge.
- R12: In mode 1000, a rising trigger edge reinitialises the count, pulses `update_o` and sets the run flag.
- R13: A change on the trigger or a channel input takes effect on the third rising clock edge after it.
- R14: `down_o` follows `dir_i` one cycle later in the non-encoder modes. In the encoder modes it shows the direction of the last encoder step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 4 | Slave mode code |
| en_i | input | 1 | Enable level; each change is copied into the run flag |
| dir_i | input | 1 | Count direction for the non-encoder modes (1 = down) |
| arr_i | input | W | Auto-reload value |
| trg_i | input | 1 | Trigger input, asynchronous |
| ch1_i | input | 1 | Encoder channel 1, asynchronous |
| ch2_i | input | 1 | Encoder channel 2, asynchronous |
| count_o | output | W | Counter value |
| down_o | output | 1 | Current counting direction (1 = down) |
| update_o | output | 1 | One-cycle update pulse on wrap or reinitialisation |

## Verification
A change of `en_i` reaches the run flag at the next edge, so free counting begins one edge later. This is why the vector table expects one step fewer than the number of edges waited. A trigger or channel change crosses two synchroniser flops and acts on the third edge. The directed tests therefore check the count both after two edges, when it must be unchanged, and after the third, when the action must be visible. `update_o` and `down_o` are registered together with the count, so they are sampled on the same falling edge as the count they belong to.

// File: rtl/slave_timer_ctrl.sv
module slave_timer_ctrl #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   mode_i,
  input  logic         en_i,
  input  logic         dir_i,
  input  logic [W-1:0] arr_i,
  input  logic         trg_i,
  input  logic         ch1_i,
  input  logic         ch2_i,
  output logic [W-1:0] count_o,
  output logic         down_o,
  output logic         update_o
);

  localparam logic [3:0] M_ENC1 = 4'd1;
  localparam logic [3:0] M_ENC2 = 4'd2;
  localparam logic [3:0] M_ENC3 = 4'd3;
  localparam logic [3:0] M_RST  = 4'd4;
  localparam logic [3:0] M_GATE = 4'd5;
  localparam logic [3:0] M_TRIG = 4'd6;
  localparam logic [3:0] M_EXT  = 4'd7;
  localparam logic [3:0] M_COMB = 4'd8;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic [2:0] trg_s, c1_s, c2_s;
  logic       en_q, cen_q;
  logic       step, sdown, reinit, start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trg_s <= '0;
      c1_s  <= '0;
      c2_s  <= '0;
    end else begin
      trg_s <= {trg_s[1:0], trg_i};
      c1_s  <= {c1_s[1:0], ch1_i};
      c2_s  <= {c2_s[1:0], ch2_i};
    end
  end

  wire trg_lvl  = trg_s[1];
  wire trg_rise = trg_s[1] & ~trg_s[2];
  wire c1_lvl   = c1_s[1];
  wire c2_lvl   = c2_s[1];
  wire c1_edge  = c1_s[1] ^ c1_s[2];
  wire c2_edge  = c2_s[1] ^ c2_s[2];
  wire c1_down  = (c1_lvl == c2_lvl);
  wire c2_down  = (c2_lvl != c1_lvl);
  wire enc_mode = (mode_i == M_ENC1) || (mode_i == M_ENC2) || (mode_i == M_ENC3);

  always_comb begin
    step   = 1'b0;
    sdown  = dir_i;
    reinit = 1'b0;
    start  = 1'b0;
    case (mode_i)
      M_ENC1: begin
        step  = cen_q & c1_edge;
        sdown = c1_down;
      end
      M_ENC2: begin
        step  = cen_q & c2_edge;
        sdown = c2_down;
      end
      M_ENC3: begin
        step  = cen_q & (c1_edge ^ c2_edge);
        sdown = c1_edge ? c1_down : c2_down;
      end
      M_RST: begin
        reinit = trg_rise;
        step   = cen_q;
      end
      M_GATE: step = cen_q & trg_lvl;
      M_TRIG: begin
        start = trg_rise;
        step  = cen_q;
      end
      M_EXT:  step = cen_q & trg_rise;
      M_COMB: begin
        reinit = trg_rise;
        start  = trg_rise;
        step   = cen_q;
      end
      default: step = cen_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cen_q <= 1'b0;
    end else begin
      en_q <= en_i;
      if (start)              cen_q <= 1'b1;
      else if (en_i != en_q)  cen_q <= en_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o  <= '0;
      update_o <= 1'b0;
      down_o   <= 1'b0;
    end else begin
      update_o <= 1'b0;
      if (!enc_mode)  down_o <= dir_i;
      else if (step)  down_o <= sdown;
      if (reinit) begin
        count_o  <= dir_i ? arr_i : '0;
        update_o <= 1'b1;
      end else if (step) begin
        if (sdown) begin
          if (count_o == '0) begin
            count_o  <= arr_i;
            update_o <= 1'b1;
          end else begin
            count_o <= count_o - ONE;
          end
        end else begin
          if (count_o >= arr_i) begin
            count_o  <= '0;
            update_o <= 1'b1;
          end else begin
            count_o <= count_o + ONE;
          end
        end
      end
    end
  end

  // R3
  upd_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update_o |-> (count_o == '0 || count_o == $past(arr_i)));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_q && !reinit) |=> $stable(count_o));

  // R9
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == M_GATE && !trg_lvl) |=> $stable(count_o));

  // R7
  enc_one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enc_mode |=> (update_o || count_o == $past(count_o) ||
                  count_o == $past(count_o) + ONE || count_o == $past(count_o) - ONE));

  // R12
  comb_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == M_COMB && trg_rise) |=> (update_o && cen_q));

  // R10
  trig_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == M_TRIG && trg_rise) |=> (cen_q && $stable(count_o)));

endmodule

// File: tb/slave_timer_ctrl_test.sv
module slave_timer_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mode_i = '0;
  logic        en_i = 1'b0, dir_i = 1'b0;
  logic [15:0] arr_i = '0;
  logic        trg_i = 1'b0, ch1_i = 1'b0, ch2_i = 1'b0;
  logic [15:0] count_o;
  logic        down_o, update_o;
  int          total = 0, fails = 0;

  always #2 clk = ~clk;

  slave_timer_ctrl #(.W(16)) uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .en_i(en_i), .dir_i(dir_i),
    .arr_i(arr_i), .trg_i(trg_i), .ch1_i(ch1_i), .ch2_i(ch2_i),
    .count_o(count_o), .down_o(down_o), .update_o(update_o));

  // {mode, en, dir, arr, edges waited, expected count}
  localparam int NV = 13;
  localparam logic [53:0] VEC [NV] = '{
    {4'd0,  1'b1, 1'b0, 16'd10,  16'd5,  16'd4},   // R2
    {4'd0,  1'b1, 1'b0, 16'd3,   16'd6,  16'd1},   // R3
    {4'd0,  1'b1, 1'b1, 16'd5,   16'd4,  16'd3},   // R2 R3
    {4'd0,  1'b0, 1'b0, 16'd10,  16'd6,  16'd0},   // R4
    {4'd9,  1'b1, 1'b0, 16'd100, 16'd11, 16'd10},  // R2
    {4'd15, 1'b1, 1'b1, 16'd7,   16'd3,  16'd6},   // R2
    {4'd12, 1'b1, 1'b0, 16'd2,   16'd4,  16'd0},   // R2
    {4'd4,  1'b1, 1'b0, 16'd50,  16'd8,  16'd7},   // R8
    {4'd5,  1'b1, 1'b0, 16'd50,  16'd10, 16'd0},   // R9
    {4'd7,  1'b1, 1'b0, 16'd50,  16'd10, 16'd0},   // R11
    {4'd6,  1'b1, 1'b0, 16'd50,  16'd4,  16'd3},   // R10
    {4'd1,  1'b1, 1'b0, 16'd50,  16'd9,  16'd0},   // R5
    {4'd8,  1'b1, 1'b1, 16'd9,   16'd3,  16'd8}    // R12
  };

  localparam logic [1:0] FWD [4] = '{2'b10, 2'b11, 2'b01, 2'b00};
  localparam logic [1:0] REV [4] = '{2'b01, 2'b11, 2'b10, 2'b00};

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    mode_i = '0; en_i = 1'b0; dir_i = 1'b0; arr_i = '0;
    trg_i = 1'b0; ch1_i = 1'b0; ch2_i = 1'b0;
    hold(2);
    rst_n = 1'b1;
  endtask

  task automatic setup(input logic [3:0] m, input logic e, input logic d, input logic [15:0] a);
    mode_i = m; en_i = e; dir_i = d; arr_i = a;
  endtask

  task automatic quad(input bit fwd, input int cycles);
    for (int c = 0; c < cycles; c++)
      for (int s = 0; s < 4; s++) begin
        {ch1_i, ch2_i} = fwd ? FWD[s] : REV[s];
        hold(3);
      end
  endtask

  initial begin
    #600000;
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 count", count_o, 0);
    chk("R1 down", down_o, 0);
    chk("R1 update", update_o, 0);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      setup(VEC[i][53:50], VEC[i][49], VEC[i][48], VEC[i][47:32]);
      hold(int'(VEC[i][31:16]));
      chk("R2/R4/R14 table count", count_o, int'(VEC[i][15:0]));
      chk("R14 table down", down_o, int'(VEC[i][48]));
    end

    // R3 overflow and underflow pulses
    do_reset(); setup(4'd0, 1'b1, 1'b0, 16'd2);
    hold(4);
    chk("R3 up wrap count", count_o, 0);
    chk("R3 up wrap update", update_o, 1);
    hold(1);
    chk("R3 update one cycle", update_o, 0);
    chk("R3 count after wrap", count_o, 1);
    do_reset(); setup(4'd0, 1'b1, 1'b1, 16'd2);
    hold(2);
    chk("R3 down wrap count", count_o, 2);
    chk("R3 down wrap update", update_o, 1);

    // R8 / R13 reset mode
    do_reset(); setup(4'd4, 1'b1, 1'b0, 16'd100);
    hold(20);
    chk("R8 before trigger", count_o, 19);
    trg_i = 1'b1; hold(2);
    chk("R13 not yet acted", count_o, 21);
    hold(1);
    chk("R8 reinit up", count_o, 0);
    chk("R8 update", update_o, 1);
    trg_i = 1'b0;
    do_reset(); setup(4'd4, 1'b0, 1'b1, 16'd77);
    hold(3);
    chk("R4 idle", count_o, 0);
    trg_i = 1'b1; hold(3);
    chk("R8 reinit down while idle", count_o, 77);
    chk("R8 update down", update_o, 1);
    hold(3);
    chk("R4 held after reinit", count_o, 77);

    // R9 gated
    do_reset(); setup(4'd5, 1'b1, 1'b0, 16'd1000);
    trg_i = 1'b1; hold(10);
    chk("R9 gate open", count_o, 8);
    trg_i = 1'b0; hold(10);
    chk("R9 gate closed hold", count_o, 10);
    trg_i = 1'b1; hold(5);
    chk("R9 gate reopened", count_o, 13);

    // R10 trigger start
    do_reset(); setup(4'd6, 1'b0, 1'b0, 16'd1000);
    hold(5);
    chk("R10 waiting", count_o, 0);
    trg_i = 1'b1; hold(3);
    chk("R10 start no reset", count_o, 0);
    hold(5);
    chk("R10 running", count_o, 5);
    trg_i = 1'b0; hold(10);
    chk("R10 keeps running", count_o, 15);

    // R11 external clock
    do_reset(); setup(4'd7, 1'b1, 1'b0, 16'd1000);
    for (int p = 0; p < 4; p++) begin
      trg_i = 1'b1; hold(3);
      trg_i = 1'b0; hold(3);
    end
    hold(4);
    chk("R11 pulses counted", count_o, 4);

    // R12 combined
    do_reset(); setup(4'd8, 1'b0, 1'b1, 16'd300);
    hold(4);
    chk("R12 idle", count_o, 0);
    trg_i = 1'b1; hold(3);
    chk("R12 reinit", count_o, 300);
    chk("R12 update", update_o, 1);
    chk("R14 down", down_o, 1);
    hold(4);
    chk("R12 started", count_o, 296);

    // R7 both-edge encoder
    do_reset(); setup(4'd3, 1'b1, 1'b0, 16'd1000);
    quad(1'b1, 2); hold(3);
    chk("R7 forward", count_o, 8);
    chk("R14 enc up", down_o, 0);
    quad(1'b0, 1); hold(3);
    chk("R7 reverse", count_o, 4);
    chk("R14 enc down", down_o, 1);
    {ch1_i, ch2_i} = 2'b11; hold(5);
    chk("R7 simultaneous edges", count_o, 4);
    {ch1_i, ch2_i} = 2'b00; hold(5);
    chk("R7 simultaneous back", count_o, 4);

    // R5 channel-1 encoder
    do_reset(); setup(4'd1, 1'b1, 1'b0, 16'd1000);
    quad(1'b1, 2); hold(3);
    chk("R5 forward", count_o, 4);

    // R6 channel-2 encoder, underflow
    do_reset(); setup(4'd2, 1'b1, 1'b0, 16'd1000);
    quad(1'b0, 1); hold(3);
    chk("R6 reverse wrap", count_o, 999);
    chk("R14 enc2 down", down_o, 1);

    // R4 encoder idle
    do_reset(); setup(4'd3, 1'b0, 1'b0, 16'd1000);
    quad(1'b1, 1); hold(3);
    chk("R4 encoder idle", count_o, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule